// File: doc/BRIEF.md
# Test Sector Access Permission Checker

This block decides, for every read, program or erase request aimed at a 16 KB test sector, whether the request is granted or denied. The sector is two one-time-programmable 8 KB regions: a user test region in the lower half and a boot/factory region in the upper half. Requests name a 64-bit segment, not a byte. The segment index's top bit selects the region.

Each request is judged from these inputs: the operation, the segment, whether the device is in user or test mode, the program-enable input, one lock bit per region, a sticky seal and the test-interface-open input. The block also keeps a record of which 64-bit segments have already been programmed. It answers one cycle after the request with a grant/deny pulse. A deny carries a 3-bit reason code. A granted program marks its segment in the record. The array itself, ECC generation and high-voltage sequencing are handled outside this block.

Top module: `tsac_top`

## Requirements
- R1: Any request with `req_op[1]`=1 (erase, encodings 2 and 3) is denied with reason 1, in every region, mode and seal state.
- R2: `req_seg` bit 10 = 0 selects the user test region and = 1 selects the boot/factory region. Each of the 2048 index values is one 64-bit segment with its own programmed record.
- R3: In user mode (`test_mode`=0), a program (`req_op`=1) to the user test region with `prog_en`=0 is denied with reason 6. In test mode, `prog_en` is ignored.
- R4: `lock_user` denies programs to the user test region with reason 2. `lock_boot` denies programs to the boot/factory region with reason 2. Each lock has no effect on the other region.
- R5: A program to a segment already recorded as programmed is denied with reason 3. Only a granted program marks a segment, and it is seen from the next request on.
- R6: A high `seal_set` in any cycle sets the seal at that clock edge. It stays set until `rst_n` is low. A request in the same cycle as `seal_set` is judged with the seal state from before that edge.
- R7: While sealed and in test mode, reads and programs of the user test region are denied with reason 4.
- R8: While sealed, programs of the boot/factory region are denied with reason 4 in either mode.
- R9: With `tif_open`=1, programs of the boot/factory region are denied with reason 5. Reads of that region stay granted.
- R10: Reads (`req_op`=0) not covered by R7 are granted. A grant always carries reason 0.
- R11: `rsp_valid` is high for exactly the cycle after each cycle with `req_valid`=1 and is low otherwise.
- R12: Reset clears the programmed record, the seal and the response outputs.
- R13: Deny priority for the user test region is R7, then R3, then R4, then R5. For the boot/factory region it is R8, then R9, then R4, then R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models a fresh device |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 program, 2/3 erase |
| req_seg | input | 11 | 64-bit segment index; bit 10 selects region |
| test_mode | input | 1 | 1 test mode, 0 user mode |
| prog_en | input | 1 | User-mode program enable for the user test region |
| lock_user | input | 1 | Program lock, user test region |
| lock_boot | input | 1 | Program lock, boot/factory region |
| seal_set | input | 1 | Sets the sticky seal |
| tif_open | input | 1 | Test interface open |
| rsp_valid | output | 1 | Response pulse |
| rsp_grant | output | 1 | 1 granted, 0 denied |
| rsp_reason | output | 3 | Deny reason (0 on grant) |

## Verification
Two things can land in the same clock edge and interact: the seal turning on while a request is judged, and a granted program marking a segment while the next request targets that same segment. The bench raises `seal_set` in the same cycle as requests that the seal would change, and expects the pre-seal verdict for that request and the sealed verdict for the next one. It also issues back-to-back programs to one segment, expecting a grant and then reason 3. Random traffic draws from a small pool of segments so that such collisions happen often. Every verdict is compared with a reference model in the bench.

// File: rtl/tsac_pkg.sv
package tsac_pkg;
    typedef enum logic [2:0] {
        RSN_NONE     = 3'd0,
        RSN_ERASE    = 3'd1,
        RSN_LOCK     = 3'd2,
        RSN_USED     = 3'd3,
        RSN_SEALED   = 3'd4,
        RSN_RDONLY   = 3'd5,
        RSN_NOENABLE = 3'd6
    } reason_e;

    localparam logic [1:0] OP_READ = 2'd0;
    localparam logic [1:0] OP_PROG = 2'd1;
endpackage

// File: rtl/tsac_rules.sv
module tsac_rules
    import tsac_pkg::*;
(
    input  logic       op_erase,
    input  logic       op_prog,
    input  logic       in_boot,
    input  logic       test_mode,
    input  logic       prog_en,
    input  logic       lock_user,
    input  logic       lock_boot,
    input  logic       sealed,
    input  logic       tif_open,
    input  logic       seg_used,
    output logic       grant,
    output reason_e    reason
);
    always_comb begin
        grant  = 1'b0;
        reason = RSN_NONE;
        if (op_erase) begin
            reason = RSN_ERASE;
        end else if (!in_boot) begin
            if (sealed && test_mode)         reason = RSN_SEALED;
            else if (!op_prog)               grant  = 1'b1;
            else if (!test_mode && !prog_en) reason = RSN_NOENABLE;
            else if (lock_user)              reason = RSN_LOCK;
            else if (seg_used)               reason = RSN_USED;
            else                             grant  = 1'b1;
        end else begin
            if (!op_prog)                    grant  = 1'b1;
            else if (sealed)                 reason = RSN_SEALED;
            else if (tif_open)               reason = RSN_RDONLY;
            else if (lock_boot)              reason = RSN_LOCK;
            else if (seg_used)               reason = RSN_USED;
            else                             grant  = 1'b1;
        end
    end

    always_comb begin
        assert_grant_clean_R10: assert (!grant || reason == RSN_NONE);
    end
endmodule

// File: rtl/tsac_seg_record.sv
module tsac_seg_record #(
    parameter int SEG_W = 11,
    localparam int NSEG = 1 << SEG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEG_W-1:0] idx,
    input  logic             mark,
    output logic             used
);
    logic [NSEG-1:0] rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (mark) rec_d[idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign used = rec_q[idx];

    assert_record_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((rec_q & $past(rec_q)) == $past(rec_q)));
    assert_mark_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> $past(used) == 1'b0 || $past(mark) == 1'b0 || rec_q[$past(idx)]);
endmodule

// File: rtl/tsac_top.sv
module tsac_top
    import tsac_pkg::*;
#(
    parameter int SEG_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [SEG_W-1:0] req_seg,
    input  logic             test_mode,
    input  logic             prog_en,
    input  logic             lock_user,
    input  logic             lock_boot,
    input  logic             seal_set,
    input  logic             tif_open,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic [2:0]       rsp_reason
);
    typedef struct packed {
        logic    seal;
        logic    vld;
        logic    grant;
        reason_e reason;
    } state_t;

    state_t  st_d, st_q;
    logic    seg_used, rule_grant, mark;
    reason_e rule_reason;

    tsac_rules u_rules (
        .op_erase  (req_op[1]),
        .op_prog   (req_op == OP_PROG),
        .in_boot   (req_seg[SEG_W-1]),
        .test_mode (test_mode),
        .prog_en   (prog_en),
        .lock_user (lock_user),
        .lock_boot (lock_boot),
        .sealed    (st_q.seal),
        .tif_open  (tif_open),
        .seg_used  (seg_used),
        .grant     (rule_grant),
        .reason    (rule_reason)
    );

    assign mark = req_valid && rule_grant && (req_op == OP_PROG);

    tsac_seg_record #(.SEG_W(SEG_W)) u_record (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (req_seg),
        .mark  (mark),
        .used  (seg_used)
    );

    always_comb begin
        st_d        = st_q;
        st_d.seal   = st_q.seal | seal_set;
        st_d.vld    = req_valid;
        st_d.grant  = req_valid & rule_grant;
        st_d.reason = req_valid ? rule_reason : RSN_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{seal: 1'b0, vld: 1'b0, grant: 1'b0, reason: RSN_NONE};
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.vld;
    assign rsp_grant  = st_q.grant;
    assign rsp_reason = st_q.reason;

    assert_erase_denied_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[1]) |=> (!rsp_grant && rsp_reason == RSN_ERASE));
    assert_seal_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seal |=> st_q.seal);
    assert_sealed_user_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st_q.seal && test_mode && !req_seg[SEG_W-1]) |=> !rsp_grant);
    assert_sealed_boot_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st_q.seal && req_op == OP_PROG && req_seg[SEG_W-1]) |=> !rsp_grant);
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant));
endmodule

// File: tb/test_tsac_top.sv
module test_tsac_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [10:0] req_seg = '0;
    logic        test_mode = 1'b0, prog_en = 1'b0, lock_user = 1'b0, lock_boot = 1'b0;
    logic        seal_set = 1'b0, tif_open = 1'b0;
    logic        rsp_valid, rsp_grant;
    logic [2:0]  rsp_reason;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    bit m_rec [2048];
    bit m_seal;

    always #10 clk = ~clk;

    tsac_top i_tsac_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_seg(req_seg),
        .test_mode(test_mode), .prog_en(prog_en), .lock_user(lock_user), .lock_boot(lock_boot),
        .seal_set(seal_set), .tif_open(tif_open),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_reason(rsp_reason)
    );

    function automatic logic [3:0] verdict(logic [1:0] op, logic [10:0] seg, logic tm,
                                           logic pe, logic lu, logic lb, logic tif);
        if (op[1]) return {1'b0, 3'd1};
        if (!seg[10]) begin
            if (m_seal && tm) return {1'b0, 3'd4};
            if (op == 2'd0)   return {1'b1, 3'd0};
            if (!tm && !pe)   return {1'b0, 3'd6};
            if (lu)           return {1'b0, 3'd2};
            if (m_rec[seg])   return {1'b0, 3'd3};
            return {1'b1, 3'd0};
        end
        if (op == 2'd0) return {1'b1, 3'd0};
        if (m_seal)     return {1'b0, 3'd4};
        if (tif)        return {1'b0, 3'd5};
        if (lb)         return {1'b0, 3'd2};
        if (m_rec[seg]) return {1'b0, 3'd3};
        return {1'b1, 3'd0};
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got v/g/r=%b/%b/%0d expected %b/%b/%0d", tag,
                     act[4], act[3], act[2:0], exp[4], exp[3], exp[2:0]);
        end
    endtask

    task automatic send(string tag, logic [1:0] op, logic [10:0] seg, logic tm, logic pe,
                        logic lu, logic lb, logic tif, logic ss);
        logic [3:0] e;
        e = verdict(op, seg, tm, pe, lu, lb, tif);
        req_valid = 1'b1; req_op = op; req_seg = seg; test_mode = tm; prog_en = pe;
        lock_user = lu; lock_boot = lb; tif_open = tif; seal_set = ss;
        if (e[3] && op == 2'd1) m_rec[seg] = 1'b1;
        if (ss) m_seal = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; seal_set = 1'b0;
        check(tag, {rsp_valid, rsp_grant, rsp_reason}, {1'b1, e});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; seal_set = 1'b0;
        foreach (m_rec[i]) m_rec[i] = 1'b0;
        m_seal = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: got hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R12: reset state
        check("R12 reset outputs", {rsp_valid, rsp_grant, rsp_reason}, 5'b0);
        // R1: erase denied everywhere
        send("R1 erase user region", 2'd2, 11'h005, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send("R1 erase boot region code3", 2'd3, 11'h405, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3: user mode needs prog_en, test mode ignores it
        send("R3 no enable", 2'd1, 11'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        send("R3 test mode ignores enable", 2'd1, 11'h010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5: second program same segment, back to back
        send("R5 reprogram denied", 2'd1, 11'h010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4: locks independent, R13 priority enable before lock
        send("R4 user lock", 2'd1, 11'h011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send("R4 boot lock ignores user side", 2'd1, 11'h411, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        send("R4 boot lock", 2'd1, 11'h412, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send("R13 enable before lock", 2'd1, 11'h013, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R9: test interface open
        send("R9 boot read-only", 2'd1, 11'h420, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        send("R9 boot read ok", 2'd0, 11'h420, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        // R2: segment 0x020 in user region is distinct from 0x420
        send("R2 region split", 2'd1, 11'h020, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send("R2 boot seg own record", 2'd1, 11'h420, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R11: idle cycle
        @(negedge clk);
        check("R11 idle", {rsp_valid, rsp_grant, rsp_reason}, 5'b0);
        // R6: seal in same cycle judged with old state
        send("R6 same-cycle seal", 2'd0, 11'h030, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send("R7 sealed test read", 2'd0, 11'h030, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send("R7 sealed user-mode read", 2'd0, 11'h030, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send("R7 sealed user-mode virgin prog", 2'd1, 11'h031, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send("R8 sealed boot prog", 2'd1, 11'h431, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        send("R10 sealed boot read", 2'd0, 11'h431, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // random traffic over a small segment pool
        for (int n = 0; n < 3000; n++) begin
            logic [10:0] s;
            s = {1'($urandom), 6'd0, 4'($urandom)};
            if (($urandom % 7) == 0) begin
                @(negedge clk);
                check("R11 random idle", {rsp_valid, rsp_grant, rsp_reason}, 5'b0);
            end
            if (n == 1500) begin
                do_reset();
                send("R12 record cleared", 2'd1, 11'h010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
            end
            send("R13 random", 2'($urandom), s, 1'($urandom), 1'($urandom),
                 (($urandom % 4) == 0), (($urandom % 4) == 0), (($urandom % 4) == 0),
                 (($urandom % 200) == 0));
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule